// File: doc/BRIEF.md
# Secure Enclave Availability Tracker

This block holds the single bit that tells software whether the secure-enclave feature may be used. Software reads the bit through a capability query. The bit rises only under three conditions: the feature has been switched on, every supported enable bit in every machine-check bank control register is set, and nothing has happened since reset that disqualifies the platform. Two kinds of event disqualify it. One is a machine-check exception that arrives after the feature was switched on. The other is a register write that turns any supported enable bit from 1 to 0. Both set a sticky disable that only reset clears.

The block also watches machine-check traffic and power-state changes. When a machine-check exception or a corrected-error interrupt arrives while the core runs inside an enclave, the block raises a one-cycle request for an asynchronous enclave exit. When the platform enters a deep sleep state (S3, S4 or S5), the block emits a one-cycle enclave-destroy pulse, because enclave memory does not survive power-down. The bank control registers live inside the block, and software reads them back through an index port. The machine-check banks themselves and error logging are handled elsewhere.

Top module: `enclave_avail_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every bank control register reads 0, `featureAvail` is 0, and neither `aexReq` nor `enclaveDestroy` is high.
- R2: A write stores only the supported bit positions of the addressed bank. With the default parameters the supported masks are 0x7F, 0x0F, 0xFF and 0x3F for banks 0 to 3. Unsupported positions read back as 0 on `bankRdData` in every cycle.
- R3: `featureAvail` is 1 exactly when three things hold: a `featureEnable` pulse has been seen, every supported bit of every bank reads 1, and the sticky disable is clear. The bit reflects a write or enable sampled on a clock edge right after that edge.
- R4: A `mcExcp` sampled after the edge on which `featureEnable` was first sampled sets the sticky disable. `featureAvail` then stays 0 until reset, whatever is written or enabled later.
- R5: A `mcExcp` sampled before, or on the same edge as, the first `featureEnable` does not set the sticky disable.
- R6: A write that changes any supported bit of any bank from 1 to 0 sets the sticky disable, even if the bit is written back to 1 later.
- R7: A corrected-error interrupt (`cmciEvt`) never changes `featureAvail`.
- R8: `aexReq` goes high for exactly one cycle after the first edge on which `inEnclave` is 1 and `mcExcp` or `cmciEvt` is 1. A condition held over several cycles produces a single pulse. Events seen outside an enclave produce no request.
- R9: `sleepState` codes 0 to 5 mean S0 to S5, and codes 6 and 7 are treated as awake. `enclaveDestroy` goes high for one cycle after the edge on which `sleepState` first moves from a code outside 3..5 to a code inside 3..5. A move between two deep codes does not pulse again.
- R10: `cr4Mce` has no effect on any output.
- R11: When several bits of `bankWrEn` are set on one edge, every selected bank takes the same data. A 1-to-0 change in any of them counts for R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| featureEnable | input | 1 | Pulse that switches the enclave feature on |
| mcExcp | input | 1 | Machine-check exception strobe |
| cmciEvt | input | 1 | Corrected-error interrupt strobe |
| inEnclave | input | 1 | Core is executing inside an enclave |
| bankWrEn | input | NUM_BANKS | Per-bank write enable for the control registers |
| bankWrData | input | CTL_W | Write data shared by all banks |
| bankRdIdx | input | IDX_W | Bank selected for readback |
| cr4Mce | input | 1 | Machine-check enable bit from control register 4 (no effect) |
| sleepState | input | 3 | Current sleep-state code, 0 to 5 meaning S0 to S5 |
| featureAvail | output | 1 | Enclave feature availability bit |
| aexReq | output | 1 | One-cycle asynchronous enclave exit request |
| enclaveDestroy | output | 1 | One-cycle enclave-destroy pulse |
| bankRdData | output | CTL_W | Contents of the selected bank control register |

## Verification
A wrong sticky disable or enable-seen flag shows on `featureAvail` one edge after the event that should have changed it. It then stays wrong until reset, so the bench keeps checking through later rewrites and enables. A corrupted bank register shows on `bankRdData` at once, and on `featureAvail` on the same cycle whenever it breaks the all-set condition. A faulty edge tracker for enclave events or sleep codes shows as a missing, doubled or stretched pulse on `aexReq` or `enclaveDestroy` in the cycle after the stimulus. For that reason the outputs are compared against the reference model on every clock.

// File: rtl/enclave_avail_pkg.sv
package enclave_avail_pkg;

  // Sleep-state codes carried on the sleepState input
  typedef enum logic [2:0] {
    SLP_S0 = 3'd0,
    SLP_S1 = 3'd1,
    SLP_S2 = 3'd2,
    SLP_S3 = 3'd3,
    SLP_S4 = 3'd4,
    SLP_S5 = 3'd5
  } sleepCode_t;

  localparam int SLEEP_W = 3;

  // Status strobes passed from the bank datapath to the control
  typedef struct packed {
    logic allSet;   // every supported bit of every bank is 1
    logic dropHit;  // a write this cycle clears a supported bit that is 1
  } bankStat_t;

  function automatic logic isDeepSleep(input logic [SLEEP_W-1:0] code);
    return (code == SLP_S3) || (code == SLP_S4) || (code == SLP_S5);
  endfunction

endpackage

// File: rtl/eat_bankfile.sv
module eat_bankfile
  import enclave_avail_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CTL_W     = 8,
  parameter logic [NUM_BANKS*CTL_W-1:0] BANK_MASK = 32'h3F_FF_0F_7F,
  parameter int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] bankWrEn,
  input  logic [CTL_W-1:0]     bankWrData,
  input  logic [IDX_W-1:0]     rdIdx,
  output logic [CTL_W-1:0]     rdData,
  output bankStat_t            stat
);

  logic [CTL_W-1:0]     bankReg [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankFull;
  logic [NUM_BANKS-1:0] bankDrop;

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    localparam logic [CTL_W-1:0] SUP = BANK_MASK[gi*CTL_W +: CTL_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             bankReg[gi] <= '0;
      else if (bankWrEn[gi]) bankReg[gi] <= bankWrData & SUP;
    end

    assign bankFull[gi] = (bankReg[gi] == SUP);
    assign bankDrop[gi] = bankWrEn[gi] && ((bankReg[gi] & SUP & ~bankWrData) != '0);

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rstN)
      bankWrEn[gi] |=> (bankReg[gi] == ($past(bankWrData) & SUP)));

    // R2
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !bankWrEn[gi] |=> $stable(bankReg[gi]));
  end

  assign stat.allSet  = &bankFull;
  assign stat.dropHit = |bankDrop;

  always_comb begin
    rdData = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (32'(rdIdx) == k) rdData = bankReg[k];
    end
  end

endmodule

// File: rtl/eat_evtctl.sv
module eat_evtctl
  import enclave_avail_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               featureEnable,
  input  logic               mcExcp,
  input  logic               cmciEvt,
  input  logic               inEnclave,
  input  logic [SLEEP_W-1:0] sleepState,
  input  bankStat_t          stat,
  output logic               featureAvail,
  output logic               aexReq,
  output logic               enclaveDestroy
);

  logic enSeen;
  logic stickyOff;
  logic qualPrev;
  logic deepPrev;
  logic qualNow;
  logic deepNow;

  assign qualNow = inEnclave && (mcExcp || cmciEvt);
  assign deepNow = isDeepSleep(sleepState);

  // Feature enable and sticky disable; only reset clears either
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSeen    <= 1'b0;
      stickyOff <= 1'b0;
    end else begin
      if (featureEnable) enSeen <= 1'b1;
      if ((mcExcp && enSeen) || stat.dropHit) stickyOff <= 1'b1;
    end
  end

  // Edge trackers for the exit request and the destroy pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualPrev       <= 1'b0;
      deepPrev       <= 1'b0;
      aexReq         <= 1'b0;
      enclaveDestroy <= 1'b0;
    end else begin
      qualPrev       <= qualNow;
      deepPrev       <= deepNow;
      aexReq         <= qualNow && !qualPrev;
      enclaveDestroy <= deepNow && !deepPrev;
    end
  end

  assign featureAvail = enSeen && stat.allSet && !stickyOff;

  // R4
  mc_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mcExcp && enSeen) |=> !featureAvail);

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stickyOff |=> stickyOff);

  // R6
  drop_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat.dropHit |=> !featureAvail);

  // R8
  aex_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    aexReq |=> !aexReq);

  // R8
  aex_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    aexReq |-> $past(inEnclave && (mcExcp || cmciEvt)));

  // R9
  destroy_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    enclaveDestroy |=> !enclaveDestroy);

  // R9
  destroy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    enclaveDestroy |-> $past(isDeepSleep(sleepState)));

endmodule

// File: rtl/enclave_avail_tracker.sv
module enclave_avail_tracker
  import enclave_avail_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CTL_W     = 8,
  parameter logic [NUM_BANKS*CTL_W-1:0] BANK_MASK = 32'h3F_FF_0F_7F,
  parameter int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 featureEnable,
  input  logic                 mcExcp,
  input  logic                 cmciEvt,
  input  logic                 inEnclave,
  input  logic [NUM_BANKS-1:0] bankWrEn,
  input  logic [CTL_W-1:0]     bankWrData,
  input  logic [IDX_W-1:0]     bankRdIdx,
  input  logic                 cr4Mce,
  input  logic [2:0]           sleepState,
  output logic                 featureAvail,
  output logic                 aexReq,
  output logic                 enclaveDestroy,
  output logic [CTL_W-1:0]     bankRdData
);

  bankStat_t bankStat;

  // The machine-check enable bit in CR4 is deliberately left without effect
  logic unusedCr4;
  assign unusedCr4 = cr4Mce;

  eat_bankfile #(
    .NUM_BANKS (NUM_BANKS),
    .CTL_W     (CTL_W),
    .BANK_MASK (BANK_MASK),
    .IDX_W     (IDX_W)
  ) u_banks (
    .clk        (clk),
    .rstN       (rstN),
    .bankWrEn   (bankWrEn),
    .bankWrData (bankWrData),
    .rdIdx      (bankRdIdx),
    .rdData     (bankRdData),
    .stat       (bankStat)
  );

  eat_evtctl u_ctl (
    .clk            (clk),
    .rstN           (rstN),
    .featureEnable  (featureEnable),
    .mcExcp         (mcExcp),
    .cmciEvt        (cmciEvt),
    .inEnclave      (inEnclave),
    .sleepState     (sleepState),
    .stat           (bankStat),
    .featureAvail   (featureAvail),
    .aexReq         (aexReq),
    .enclaveDestroy (enclaveDestroy)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!featureAvail && !aexReq && !enclaveDestroy));

endmodule

// File: tb/tb_enclave_avail_tracker.sv
`timescale 1ns/1ps
module tb_enclave_avail_tracker;

  localparam int NB = 4;
  localparam int CW = 8;
  localparam logic [NB*CW-1:0] MASKS = 32'h3F_FF_0F_7F;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          featureEnable = 1'b0;
  logic          mcExcp = 1'b0;
  logic          cmciEvt = 1'b0;
  logic          inEnclave = 1'b0;
  logic [NB-1:0] bankWrEn = '0;
  logic [CW-1:0] bankWrData = '0;
  logic [1:0]    bankRdIdx = '0;
  logic          cr4Mce = 1'b0;
  logic [2:0]    sleepState = '0;
  logic          featureAvail, aexReq, enclaveDestroy;
  logic [CW-1:0] bankRdData;

  always #4 clk = ~clk;

  enclave_avail_tracker #(.NUM_BANKS(NB), .CTL_W(CW), .BANK_MASK(MASKS)) dut (
    .clk(clk), .rstN(rstN), .featureEnable(featureEnable), .mcExcp(mcExcp),
    .cmciEvt(cmciEvt), .inEnclave(inEnclave), .bankWrEn(bankWrEn),
    .bankWrData(bankWrData), .bankRdIdx(bankRdIdx), .cr4Mce(cr4Mce),
    .sleepState(sleepState), .featureAvail(featureAvail), .aexReq(aexReq),
    .enclaveDestroy(enclaveDestroy), .bankRdData(bankRdData)
  );

  // Behavioural reference model
  int    mReg[NB];
  bit    mEn, mSticky, mQp, mDp, mAex, mDes;
  int    checks = 0;
  int    fails = 0;
  string req = "R1";

  function automatic int maskOf(int b);
    return int'((MASKS >> (b * CW)) & 32'hFF);
  endfunction

  task automatic modelUpdate();
    bit q, d;
    int nv;
    if (!rstN) begin
      foreach (mReg[b]) mReg[b] = 0;
      mEn = 0; mSticky = 0; mQp = 0; mDp = 0; mAex = 0; mDes = 0;
    end else begin
      q = inEnclave && (mcExcp || cmciEvt);
      mAex = q && !mQp;
      mQp = q;
      d = (sleepState >= 3) && (sleepState <= 5);
      mDes = d && !mDp;
      mDp = d;
      if (mcExcp && mEn) mSticky = 1;
      for (int b = 0; b < NB; b++) begin
        if (bankWrEn[b]) begin
          nv = int'(bankWrData) & maskOf(b);
          if ((mReg[b] & ~nv & maskOf(b)) != 0) mSticky = 1;
          mReg[b] = nv;
        end
      end
      if (featureEnable) mEn = 1;
    end
  endtask

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit full = 1;
    for (int b = 0; b < NB; b++) if (mReg[b] != maskOf(b)) full = 0;
    chk("featureAvail", int'(featureAvail), int'(mEn && full && !mSticky));
    chk("aexReq", int'(aexReq), int'(mAex));
    chk("enclaveDestroy", int'(enclaveDestroy), int'(mDes));
    chk("bankRdData", int'(bankRdData), mReg[bankRdIdx]);
  endtask

  task automatic step();
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [NB-1:0] en, logic [CW-1:0] data);
    bankWrEn = en; bankWrData = data;
    step();
    bankWrEn = '0;
  endtask

  task automatic fillAll();
    wr('1, 8'hFF);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) step();
    rstN = 1'b1;
    step();
  endtask

  task automatic readAll();
    for (int b = 0; b < NB; b++) begin
      bankRdIdx = 2'(b);
      step();
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired, actual hung expected done");
    finishRun();
  end

  initial begin
    // R1: reset state
    req = "R1";
    doReset();
    readAll();

    // R2: unsupported positions dropped on every bank
    req = "R2";
    for (int b = 0; b < NB; b++) begin
      bankRdIdx = 2'(b);
      wr(NB'(1) << b, 8'hFF);
      step();
    end
    wr('1, 8'h00);  // every 1 cleared here (R6 disable already, so reset next)
    doReset();

    // R5: machine check before, and on the same edge as, the enable
    req = "R5";
    mcExcp = 1; step(); mcExcp = 0;
    mcExcp = 1; featureEnable = 1; step(); mcExcp = 0; featureEnable = 0;
    // R11: one write reaches all banks
    req = "R11";
    fillAll();
    // R3: available once everything is set
    req = "R3";
    readAll();

    // R10: toggling CR4 machine-check enable does nothing
    req = "R10";
    cr4Mce = 1; step(); step(); cr4Mce = 0; step();

    // R7: corrected errors never change availability
    req = "R7";
    cmciEvt = 1; step(); cmciEvt = 0; step();

    // R8: held condition inside the enclave gives one pulse
    req = "R8";
    inEnclave = 1; cmciEvt = 1;
    repeat (3) step();
    cmciEvt = 0; step();
    cmciEvt = 1; step(); cmciEvt = 0; inEnclave = 0; step();

    // R9: destroy pulses on entry to S3, S4 or S5 only
    req = "R9";
    sleepState = 3'd1; step();
    sleepState = 3'd3; step();
    sleepState = 3'd4; step();
    sleepState = 3'd0; step();
    sleepState = 3'd5; step(); step();
    sleepState = 3'd6; step();
    sleepState = 3'd2; step();
    sleepState = 3'd0; step();

    // R6: clearing a supported bit disables until reset
    req = "R6";
    bankRdIdx = 2'd2;
    wr(4'b0100, 8'h7F);
    wr(4'b0100, 8'hFF);
    featureEnable = 1; step(); featureEnable = 0; step();

    // R3: enabled but one supported bit still low
    req = "R3";
    doReset();
    featureEnable = 1; step(); featureEnable = 0;
    wr('1, 8'hFF);
    wr(4'b1000, 8'h3F);  // rewrite same value, still available
    doReset();
    wr(4'b0111, 8'hFF);
    wr(4'b1000, 8'h1F);
    featureEnable = 1; step(); featureEnable = 0;
    wr(4'b1000, 8'h3F);

    // R4: machine check after enable, inside an enclave
    req = "R4";
    inEnclave = 1; mcExcp = 1; step(); mcExcp = 0; inEnclave = 0; step();
    fillAll();
    featureEnable = 1; step(); featureEnable = 0; step();

    // R11: a drop in one of several selected banks
    req = "R11";
    doReset();
    fillAll();
    featureEnable = 1; step(); featureEnable = 0;
    bankRdIdx = 2'd1;
    wr(4'b0011, 8'h0F);
    step();

    finishRun();
  end

endmodule